// File: doc/BRIEF.md
# Timer Core with Run Gating and Access-Triggered Flag Clearing

This block is the heart of a capture/compare timer. It holds a free-running 16-bit count, a six-bit prescaler that paces the count and also hands a divide-by-64 tick to an external pulse accumulator, an overflow flag and one event flag per capture/compare channel. A single control byte decides whether the timer runs at all. It also decides whether the timer halts while the processor sits in wait mode or in debug (background) mode, and how flags are cleared.

Flags always clear when software writes a one to their bit. When the fast-clear control bit is set, a flag also clears as a side effect of ordinary traffic. For a channel that is capturing, a read of its value register clears its flag. For a channel that is comparing, a write to its value register clears its flag. Any access to either byte of the count clears the overflow flag. This saves the separate flag write in interrupt handlers.

The pulse accumulator and the modulus down counter live elsewhere. This block only drives their halt lines and the slow tick.

Top module: `tmr_ffc_core`

## Requirements
- R1: After reset the control byte, the count, the prescaler and every flag are zero. The control byte is readable and writable at any time. It sits at address 0x00 with run-enable in bit 7, stop-in-wait in bit 6, stop-in-debug in bit 5 and fast-clear in bit 4, and its bits 3..0 always read as zero.
- R2: While run-enable is 0 the count holds its value and `pa_tick64` stays low.
- R3: While the timer is active, the count advances by one on each prescaled tick, which is every clock at the default prescale. `pa_tick64` pulses high for one clock once in every 64 active clocks.
- R4: With stop-in-wait set and `sys_wait` high, the count freezes, `pa_halt` and `mdc_halt` are high, and `tmr_irq` is held low. With stop-in-wait clear, wait mode changes nothing.
- R5: With stop-in-debug set and `sys_dbg` high, the count freezes and `mdc_halt` is high, while `pa_halt` stays low. With the bit clear, debug mode changes nothing.
- R6: The overflow flag (bit 7 at address 0x02) sets on the tick where the count wraps from 0xFFFF to 0x0000. `tmr_irq` is high whenever any flag is set, unless R4 holds it low.
- R7: A flag clears when a one is written to its bit: channel flags at address 0x01 with channel n in bit n, and overflow at 0x02 bit 7. Writing zero to a flag bit has no effect. With fast-clear off, accesses to the value registers and the count do not clear any flag.
- R8: With fast-clear on, reading either byte of a capture channel's value register clears that channel's flag, and writing either byte of a compare channel's value register clears it. Channel n's value sits at 0x10+2n (high byte) and 0x11+2n (low byte), and `ch_oc_mode[n]`=1 selects compare.
- R9: With fast-clear on, a read or a write of the count high byte (0x04) or low byte (0x05) clears the overflow flag.
- R10: When a flag's set event and its clear event fall in the same clock, the flag ends up set.
- R11: A pulse on `ch_edge[n]` for a capture channel copies the current count into its value register and sets its flag. A compare channel sets its flag on a tick where the count equals its value register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | AW | Register byte address |
| bus_rd | input | 1 | Read strobe, one clock per access |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| sys_wait | input | 1 | Processor is in wait mode |
| sys_dbg | input | 1 | Processor is in debug (background) mode |
| ch_edge | input | NCH | Per-channel capture event pulses |
| ch_oc_mode | input | NCH | Per-channel mode: 1 compare, 0 capture |
| tmr_irq | output | 1 | Timer interrupt request |
| pa_tick64 | output | 1 | Divide-by-64 tick for the pulse accumulator |
| pa_halt | output | 1 | Halt request to the pulse accumulator |
| mdc_halt | output | 1 | Halt request to the modulus down counter |

## Verification
The hardest case to reach from the ports is the clash at the top of the count. There, a write-one clear of the overflow flag arrives in exactly the clock in which the count wraps, and the set must win. The bench reaches this clash by resetting, enabling the timer with a single write and counting 65535 falling edges from the end of that write. The count has no load path, so the clear is presented in exactly the wrap clock. The same cycle arithmetic gives the plain overflow check, which watches `tmr_irq` rise on the wrap clock and not one clock earlier. It then gives the fast-clear check of the overflow flag through the count bytes.

// File: rtl/tmr_ffc_core.sv
module tmr_ffc_core #(
  parameter int NCH      = 8,
  parameter int PRE_LOG2 = 0,
  parameter int AW       = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  bus_addr,
  input  logic           bus_rd,
  input  logic           bus_wr,
  input  logic [7:0]     bus_wdata,
  output logic [7:0]     bus_rdata,
  input  logic           sys_wait,
  input  logic           sys_dbg,
  input  logic [NCH-1:0] ch_edge,
  input  logic [NCH-1:0] ch_oc_mode,
  output logic           tmr_irq,
  output logic           pa_tick64,
  output logic           pa_halt,
  output logic           mdc_halt
);

  localparam int          CW      = 16;
  localparam int          PW      = 6;
  localparam int          CH_BASE = 16;
  localparam logic [PW-1:0] PMASK = PW'((1 << PRE_LOG2) - 1);
  localparam logic [AW-1:0] A_CTL = AW'(0);
  localparam logic [AW-1:0] A_CHF = AW'(1);
  localparam logic [AW-1:0] A_OVF = AW'(2);
  localparam logic [AW-1:0] A_CNH = AW'(4);
  localparam logic [AW-1:0] A_CNL = AW'(5);

  logic          en_q, swai_q, sdbg_q, ffca_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] pre_q;
  logic          tof_q;
  logic [NCH-1:0] chf_w;
  logic [7:0]    ch_byte [NCH];
  logic [7:0]    ch_rd;

  wire wait_hold = swai_q & sys_wait;
  wire dbg_hold  = sdbg_q & sys_dbg;
  wire run       = en_q & ~wait_hold & ~dbg_hold;
  wire tick      = run && ((pre_q & PMASK) == PMASK);
  wire cnt_acc   = (bus_rd | bus_wr) && (bus_addr == A_CNH || bus_addr == A_CNL);

  wire [AW-1:0] ch_off = bus_addr - AW'(CH_BASE);
  wire          ch_hit = (bus_addr >= AW'(CH_BASE)) && (ch_off < AW'(2 * NCH));

  assign pa_tick64 = run && (pre_q == {PW{1'b1}});
  assign pa_halt   = wait_hold;
  assign mdc_halt  = wait_hold | dbg_hold;
  assign tmr_irq   = (tof_q | (|chf_w)) & ~wait_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {en_q, swai_q, sdbg_q, ffca_q} <= 4'b0;
      cnt_q <= '0;
      pre_q <= '0;
      tof_q <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == A_CTL) {en_q, swai_q, sdbg_q, ffca_q} <= bus_wdata[7:4];
      if (run)  pre_q <= pre_q + 1'b1;
      if (tick) cnt_q <= cnt_q + 1'b1;
      if (tick && cnt_q == {CW{1'b1}})
        tof_q <= 1'b1;
      else if ((ffca_q && cnt_acc) || (bus_wr && bus_addr == A_OVF && bus_wdata[7]))
        tof_q <= 1'b0;
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic [CW-1:0] val_q;
    logic          flag_q;
    wire sel   = ch_hit && (ch_off[AW-1:1] == (AW-1)'(n));
    wire cap   = ~ch_oc_mode[n] & ch_edge[n];
    wire match = ch_oc_mode[n] & tick & (cnt_q == val_q);
    wire fclr  = ffca_q & sel & (ch_oc_mode[n] ? bus_wr : bus_rd);
    wire wclr  = bus_wr && bus_addr == A_CHF && bus_wdata[n];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q  <= '0;
        flag_q <= 1'b0;
      end else begin
        if (cap)
          val_q <= cnt_q;
        else if (bus_wr && sel) begin
          if (ch_off[0]) val_q[7:0]  <= bus_wdata;
          else           val_q[15:8] <= bus_wdata;
        end
        if (cap || match)       flag_q <= 1'b1;
        else if (fclr || wclr)  flag_q <= 1'b0;
      end
    end

    assign chf_w[n]   = flag_q;
    assign ch_byte[n] = sel ? (ch_off[0] ? val_q[7:0] : val_q[15:8]) : 8'h00;
  end

  always_comb begin
    ch_rd = 8'h00;
    for (int i = 0; i < NCH; i++) ch_rd = ch_rd | ch_byte[i];
  end

  always_comb begin
    case (bus_addr)
      A_CTL:   bus_rdata = {en_q, swai_q, sdbg_q, ffca_q, 4'b0000};
      A_CHF:   bus_rdata = 8'(chf_w);
      A_OVF:   bus_rdata = {tof_q, 7'b0};
      A_CNH:   bus_rdata = cnt_q[15:8];
      A_CNL:   bus_rdata = cnt_q[7:0];
      default: bus_rdata = ch_rd;
    endcase
  end

endmodule

module tmr_ffc_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          swai,
  input logic          sdbg,
  input logic          sys_wait,
  input logic          sys_dbg,
  input logic [15:0]   cnt,
  input logic          tof,
  input logic          irq,
  input logic          tick64,
  input logic          pa_halt,
  input logic          mdc_halt,
  input logic [AW-1:0] addr,
  input logic [7:0]    rdata
);

  // R1
  ctl_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == '0) |-> (rdata[3:0] == 4'b0000));

  // R2
  cnt_moves_only_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> $past(en && !(swai && sys_wait) && !(sdbg && sys_dbg)));

  // R3
  tick64_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick64 |=> !tick64);

  // R4
  wait_irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (swai && sys_wait) |-> !irq);

  // R5
  dbg_spares_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdbg && sys_dbg && !(swai && sys_wait)) |-> (!pa_halt && mdc_halt));

  // R5
  pa_implies_mdc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pa_halt |-> mdc_halt);

  // R6
  wrap_sets_tof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt) == 16'hFFFF && cnt == 16'h0000) |-> tof);

endmodule

bind tmr_ffc_core tmr_ffc_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en_q), .swai(swai_q), .sdbg(sdbg_q),
  .sys_wait(sys_wait), .sys_dbg(sys_dbg), .cnt(cnt_q), .tof(tof_q),
  .irq(tmr_irq), .tick64(pa_tick64), .pa_halt(pa_halt), .mdc_halt(mdc_halt),
  .addr(bus_addr), .rdata(bus_rdata)
);

// File: tb/tmr_ffc_core_tb.sv
module tmr_ffc_core_tb;
  localparam int NCH = 8;
  localparam int AW  = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [AW-1:0]  bus_addr = '0;
  logic           bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]     bus_wdata = '0;
  logic [7:0]     bus_rdata;
  logic           sys_wait = 1'b0, sys_dbg = 1'b0;
  logic [NCH-1:0] ch_edge = '0, ch_oc_mode = '0;
  logic           tmr_irq, pa_tick64, pa_halt, mdc_halt;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  tmr_ffc_core #(.NCH(NCH), .PRE_LOG2(0), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_wait(sys_wait), .sys_dbg(sys_dbg),
    .ch_edge(ch_edge), .ch_oc_mode(ch_oc_mode), .tmr_irq(tmr_irq), .pa_tick64(pa_tick64),
    .pa_halt(pa_halt), .mdc_halt(mdc_halt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_edge(input int ch);
    ch_edge[ch] = 1'b1;
    @(negedge clk);
    ch_edge[ch] = 1'b0;
  endtask

  // count delta over 4 edges between two low-byte reads
  task automatic cnt_delta(output logic [7:0] d);
    logic [7:0] a, b;
    rd(6'h05, a);
    repeat (3) @(negedge clk);
    rd(6'h05, b);
    d = b - a;
  endtask

  task automatic count_ticks(output int t);
    t = 0;
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      if (pa_tick64) t++;
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(6'h00, v); chk("R1 ctrl reset", v, 8'h00);
    rd(6'h01, v); chk("R1 chan flags reset", v, 8'h00);
    rd(6'h02, v); chk("R1 ovf reset", v, 8'h00);
    rd(6'h04, v); chk("R1 cnt hi reset", v, 8'h00);
    rd(6'h05, v); chk("R1 cnt lo reset", v, 8'h00);
    chk("R1 irq reset", tmr_irq, 1'b0);
    wr(6'h00, 8'h6F);
    rd(6'h00, v); chk("R1 ctrl low nibble", v, 8'h60);
    wr(6'h00, 8'h00);
  endtask

  task automatic t_enable();
    logic [7:0] d; int t;
    cnt_delta(d); chk("R2 frozen when disabled", d, 8'd0);
    count_ticks(t); chk("R2 no tick64 when disabled", t, 0);
    wr(6'h00, 8'h80);
    cnt_delta(d); chk("R3 counts each clock", d, 8'd4);
    count_ticks(t); chk("R3 tick64 rate", t, 2);
  endtask

  task automatic t_wait();
    logic [7:0] d;
    wr(6'h00, 8'hC0);
    sys_wait = 1'b1;
    @(negedge clk);
    cnt_delta(d); chk("R4 frozen in wait", d, 8'd0);
    chk("R4 pa_halt in wait", pa_halt, 1'b1);
    chk("R4 mdc_halt in wait", mdc_halt, 1'b1);
    pulse_edge(0);
    chk("R4 irq masked in wait", tmr_irq, 1'b0);
    sys_wait = 1'b0;
    @(negedge clk);
    chk("R6 irq when flag set", tmr_irq, 1'b1);
    cnt_delta(d); chk("R4 runs after wait", d, 8'd4);
    wr(6'h00, 8'h80);
    sys_wait = 1'b1;
    @(negedge clk);
    cnt_delta(d); chk("R4 no stop bit keeps running", d, 8'd4);
    chk("R4 no stop bit pa_halt", pa_halt, 1'b0);
    chk("R4 no stop bit irq", tmr_irq, 1'b1);
    sys_wait = 1'b0;
    wr(6'h01, 8'h01);
    rd(6'h01, d); chk("R7 w1c channel 0", d, 8'h00);
  endtask

  task automatic t_dbg();
    logic [7:0] d; int t;
    wr(6'h00, 8'hA0);
    sys_dbg = 1'b1;
    @(negedge clk);
    cnt_delta(d); chk("R5 frozen in debug", d, 8'd0);
    chk("R5 mdc_halt in debug", mdc_halt, 1'b1);
    chk("R5 pa_halt stays low in debug", pa_halt, 1'b0);
    count_ticks(t); chk("R5 no tick64 in debug", t, 0);
    wr(6'h00, 8'h80);
    cnt_delta(d); chk("R5 no stop bit keeps running", d, 8'd4);
    chk("R5 no stop bit mdc_halt", mdc_halt, 1'b0);
    sys_dbg = 1'b0;
  endtask

  task automatic t_normal_clear();
    logic [7:0] h, l, v;
    wr(6'h00, 8'h00);
    rd(6'h04, h); rd(6'h05, l);
    pulse_edge(3);
    rd(6'h01, v); chk("R11 capture sets flag", v, 8'h08);
    rd(6'h16, v); chk("R11 capture hi", v, h);
    rd(6'h17, v); chk("R11 capture lo", v, l);
    rd(6'h01, v); chk("R7 read keeps flag", v, 8'h08);
    wr(6'h01, 8'hF7);
    rd(6'h01, v); chk("R7 write zero no effect", v, 8'h08);
    wr(6'h01, 8'h08);
    rd(6'h01, v); chk("R7 write one clears", v, 8'h00);
  endtask

  task automatic t_fast_clear();
    logic [7:0] h, l, v;
    logic [15:0] c;
    wr(6'h00, 8'h10);
    pulse_edge(3);
    rd(6'h01, v); chk("R8 capture flag set", v, 8'h08);
    rd(6'h17, v);
    rd(6'h01, v); chk("R8 capture read clears", v, 8'h00);
    ch_oc_mode[6] = 1'b1;
    rd(6'h04, h); rd(6'h05, l);
    c = {h, l} + 16'd2;
    wr(6'h1C, c[15:8]); wr(6'h1D, c[7:0]);
    wr(6'h00, 8'h90);
    repeat (5) @(negedge clk);
    wr(6'h00, 8'h10);
    rd(6'h01, v); chk("R11 compare match sets flag", v, 8'h40);
    rd(6'h1C, v);
    rd(6'h01, v); chk("R8 compare read keeps flag", v, 8'h40);
    wr(6'h1D, c[7:0]);
    rd(6'h01, v); chk("R8 compare write clears", v, 8'h00);
    ch_oc_mode[6] = 1'b0;
  endtask

  task automatic t_overflow();
    logic [7:0] v;
    do_reset();
    wr(6'h00, 8'h80);
    repeat (65535) @(negedge clk);
    chk("R6 no flag before wrap", tmr_irq, 1'b0);
    @(negedge clk);
    chk("R6 irq at wrap", tmr_irq, 1'b1);
    rd(6'h02, v); chk("R6 ovf flag set", v, 8'h80);
    rd(6'h05, v);
    rd(6'h02, v); chk("R7 count read keeps ovf", v, 8'h80);
    wr(6'h00, 8'h90);
    rd(6'h04, v);
    rd(6'h02, v); chk("R9 count read clears ovf", v, 8'h00);
  endtask

  task automatic t_collision();
    logic [7:0] v;
    do_reset();
    wr(6'h00, 8'h80);
    repeat (65535) @(negedge clk);
    wr(6'h02, 8'h80);
    rd(6'h02, v); chk("R10 set wins over clear", v, 8'h80);
    wr(6'h02, 8'h80);
    rd(6'h02, v); chk("R7 ovf write one clears", v, 8'h00);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_enable();
    t_wait();
    t_dbg();
    t_normal_clear();
    t_fast_clear();
    t_overflow();
    t_collision();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule